// File: doc/BRIEF.md
# Per-Car Brake Force Sequencer

This block is the brake controller of one car in a train. It keeps the car's brake force at one of three levels (none, medium, high). It raises that level when the emergency lever is pulled, when a neighbouring car reports a higher force, or when a trackside distance sensor fires while the train runs fast. Every rise is passed along the train through request/acknowledge handshakes with the cars on the left and on the right. A rise started locally informs the left car first and the right car after it. A rise received from one side is acknowledged to that side and forwarded to the opposite side. The new force is applied only after the last neighbour has acknowledged. When the train has stopped and nothing is pending, the brakes are released.

The controller is a synchronous state machine with one idle state and a few handshake states. The force level, the level being forwarded and the sensor that fired are held in a small datapath. The inter-car transport and the physical actuators sit outside the block.

Top module: `brake_car_ctrl`

## Requirements
- R1: After reset `forceLvl` is 0 and `txLeftReq`, `txRightReq`, `leftAckOut`, `rightAckOut` and `sensAck` are all low.
- R2: In the idle state, with no lever, no neighbour message, no sensor pulse and `speedLvl` not 0, the force and every output stay unchanged.
- R3: Lever high in idle with force below 2 starts this sequence: `txLeftReq` with `txForce`=2 until `leftAckIn`, then `txRightReq` with `txForce`=2 until `rightAckIn`, then `forceLvl`=2 in the cycle after that acknowledge. With force already 2 the lever is ignored.
- R4: A left message (`rxLeftValid` held high with level `rxLeftForce`, dropped by the neighbour in the cycle after our acknowledge) is answered by a one-cycle `leftAckOut`. If its level exceeds the force, the level is sent right (`txRightReq`, `txForce`=level) and adopted in the cycle after `rightAckIn`. Otherwise the controller returns to idle with the force unchanged.
- R5: A right message is handled the same way with the sides swapped: a one-cycle `rightAckOut`, then, only if the level is higher, `txLeftReq` with that level and adoption after `leftAckIn`.
- R6: Each outgoing request stays high until its acknowledge input is seen and is low in the following cycle. `txForce` holds the level being sent for as long as a request is high.
- R7: A one-cycle pulse on `distSense` bit i (bit 0 is sensor 1) gives a one-cycle `sensAck` with only bit i set. After that, if `speedLvl` is 2 or more and the force is below 2, the R3 left-then-right sequence runs to force 2. Otherwise the force is unchanged.
- R8: Events seen in the same idle cycle are served in this order: lever, left message, right message, sensor 1, sensor 2, sensor 3. A lever or message that is still held is served on a later return to idle. Sensor pulses that lose are dropped.
- R9: In idle with no event, `speedLvl`=0 and force not 0, the force becomes 0 in the next cycle and no message is sent.
- R10: At most one of `txLeftReq`, `txRightReq`, `leftAckOut`, `rightAckOut` and the bits of `sensAck` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| emergLever | input | 1 | Emergency lever pulled (level) |
| distSense | input | NUM_SENSORS | Trackside distance sensor pulses, bit 0 = sensor 1 |
| speedLvl | input | SPEED_W | Speed: 0 stopped, 1 medium, 2+ high |
| rxLeftValid | input | 1 | Force message from left neighbour (level until acknowledged) |
| rxLeftForce | input | FORCE_W | Force level carried by the left message |
| rxRightValid | input | 1 | Force message from right neighbour |
| rxRightForce | input | FORCE_W | Force level carried by the right message |
| leftAckIn | input | 1 | Left neighbour acknowledges our request |
| rightAckIn | input | 1 | Right neighbour acknowledges our request |
| forceLvl | output | FORCE_W | Applied brake force, 0 to 2 |
| txLeftReq | output | 1 | Force request to left neighbour |
| txRightReq | output | 1 | Force request to right neighbour |
| txForce | output | FORCE_W | Level carried by the active request |
| leftAckOut | output | 1 | One-cycle acknowledge to left neighbour |
| rightAckOut | output | 1 | One-cycle acknowledge to right neighbour |
| sensAck | output | NUM_SENSORS | One-cycle acknowledge of the served sensor |

## Verification
The bench makes two sources of a rise collide in one idle cycle. It pulls the lever in the same cycle that a left message arrives, it raises left and right messages together, and it pulses two sensors at once. The scoreboard expects the winner's handshake in full, then the force commit, then the loser's acknowledge served from idle. For the loser, which is no longer higher, it expects no forwarding. For the two sensors it expects only the lower-numbered acknowledge. The neighbour responders check that each request falls in the cycle after its acknowledge, and any event the scoreboard does not expect is counted as a mismatch.

// File: rtl/brake_pkg.sv
package brake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_L,
    ST_ACK_R,
    ST_SENSE,
    ST_TXL_FIRST,
    ST_TXR_LAST,
    ST_TXL_LAST
  } ctrlState_t;

  typedef enum logic [1:0] {
    TGT_MAX,
    TGT_LEFT,
    TGT_RIGHT
  } tgtSrc_t;

  typedef struct packed {
    logic    loadTarget;
    tgtSrc_t tgtSrc;
    logic    commit;
    logic    clearForce;
    logic    latchSensor;
  } dpStrobe_t;

endpackage

// File: rtl/brake_datapath.sv
module brake_datapath
  import brake_pkg::*;
#(
  parameter int FORCE_W     = 2,
  parameter int NUM_SENSORS = 3,
  parameter int MAX_FORCE   = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [FORCE_W-1:0]     rxLeftForce,
  input  logic [FORCE_W-1:0]     rxRightForce,
  input  logic [NUM_SENSORS-1:0] distSense,
  output logic [FORCE_W-1:0]     forceLvl,
  output logic [FORCE_W-1:0]     targetLvl,
  output logic                   targetAbove,
  output logic                   forceBelowMax,
  output logic                   sensorHit,
  output logic [NUM_SENSORS-1:0] sensorSel
);

  localparam logic [FORCE_W-1:0] MAX_LVL = FORCE_W'(MAX_FORCE);

  logic [FORCE_W-1:0]     forceReg;
  logic [FORCE_W-1:0]     targetReg;
  logic [FORCE_W-1:0]     targetNext;
  logic [NUM_SENSORS-1:0] sensSelReg;
  logic [NUM_SENSORS-1:0] firstSens;

  // Lowest-numbered active sensor wins: scan from the top so the last hit sticks.
  always_comb begin
    firstSens = '0;
    for (int i = NUM_SENSORS - 1; i >= 0; i--) begin
      if (distSense[i]) begin
        firstSens    = '0;
        firstSens[i] = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (strobe.tgtSrc)
      TGT_LEFT:  targetNext = rxLeftForce;
      TGT_RIGHT: targetNext = rxRightForce;
      default:   targetNext = MAX_LVL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceReg   <= '0;
      targetReg  <= '0;
      sensSelReg <= '0;
    end else begin
      if (strobe.loadTarget)  targetReg  <= targetNext;
      if (strobe.latchSensor) sensSelReg <= firstSens;
      if (strobe.commit)          forceReg <= targetReg;
      else if (strobe.clearForce) forceReg <= '0;
    end
  end

  assign forceLvl      = forceReg;
  assign targetLvl     = targetReg;
  assign targetAbove   = targetReg > forceReg;
  assign forceBelowMax = forceReg < MAX_LVL;
  assign sensorHit     = |distSense;
  assign sensorSel     = sensSelReg;

  // R3: the applied force never leaves the legal range
  assert_force_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    forceReg <= MAX_LVL);

  // R7: the latched sensor selection names at most one sensor
  assert_sensor_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sensSelReg));

  // R9: a release strobe without a commit leaves the force at zero
  assert_release_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearForce && !strobe.commit) |=> (forceReg == '0));

endmodule

// File: rtl/brake_control.sv
module brake_control
  import brake_pkg::*;
#(
  parameter int FORCE_W    = 2,
  parameter int SPEED_W    = 2,
  parameter int HIGH_SPEED = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               emergLever,
  input  logic               rxLeftValid,
  input  logic               rxRightValid,
  input  logic               leftAckIn,
  input  logic               rightAckIn,
  input  logic               sensorHit,
  input  logic [SPEED_W-1:0] speedLvl,
  input  logic [FORCE_W-1:0] forceLvl,
  input  logic               forceBelowMax,
  input  logic               targetAbove,
  output dpStrobe_t          strobe,
  output logic               txLeftReq,
  output logic               txRightReq,
  output logic               leftAckOut,
  output logic               rightAckOut,
  output logic               senseAckEn
);

  localparam logic [SPEED_W-1:0] HIGH_LVL = SPEED_W'(HIGH_SPEED);

  ctrlState_t state;
  ctrlState_t stateNext;
  logic       speedHigh;
  logic       anyEvent;
  logic       inIdle;

  assign speedHigh = speedLvl >= HIGH_LVL;
  assign anyEvent  = emergLever | rxLeftValid | rxRightValid | sensorHit;
  assign inIdle    = state == ST_IDLE;

  always_comb begin
    stateNext = state;
    strobe    = '{loadTarget: 1'b0, tgtSrc: TGT_MAX, commit: 1'b0,
                  clearForce: 1'b0, latchSensor: 1'b0};
    unique case (state)
      ST_IDLE: begin
        if (emergLever && forceBelowMax) begin
          strobe.loadTarget = 1'b1;
          strobe.tgtSrc     = TGT_MAX;
          stateNext         = ST_TXL_FIRST;
        end else if (rxLeftValid) begin
          strobe.loadTarget = 1'b1;
          strobe.tgtSrc     = TGT_LEFT;
          stateNext         = ST_ACK_L;
        end else if (rxRightValid) begin
          strobe.loadTarget = 1'b1;
          strobe.tgtSrc     = TGT_RIGHT;
          stateNext         = ST_ACK_R;
        end else if (sensorHit) begin
          strobe.latchSensor = 1'b1;
          stateNext          = ST_SENSE;
        end else if (!emergLever && speedLvl == '0 && forceLvl != '0) begin
          strobe.clearForce = 1'b1;
        end
      end
      ST_ACK_L: stateNext = targetAbove ? ST_TXR_LAST : ST_IDLE;
      ST_ACK_R: stateNext = targetAbove ? ST_TXL_LAST : ST_IDLE;
      ST_SENSE: begin
        if (speedHigh && forceBelowMax) begin
          strobe.loadTarget = 1'b1;
          strobe.tgtSrc     = TGT_MAX;
          stateNext         = ST_TXL_FIRST;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_TXL_FIRST: if (leftAckIn) stateNext = ST_TXR_LAST;
      ST_TXR_LAST: begin
        if (rightAckIn) begin
          strobe.commit = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_TXL_LAST: begin
        if (leftAckIn) begin
          strobe.commit = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign txLeftReq   = (state == ST_TXL_FIRST) || (state == ST_TXL_LAST);
  assign txRightReq  = state == ST_TXR_LAST;
  assign leftAckOut  = state == ST_ACK_L;
  assign rightAckOut = state == ST_ACK_R;
  assign senseAckEn  = state == ST_SENSE;

  // R3: lever at sub-maximum force opens the left handshake next cycle
  assert_lever_starts_left_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && emergLever && forceBelowMax) |=> txLeftReq);

  // R4: acknowledge to the left is a single-cycle pulse
  assert_left_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    leftAckOut |=> !leftAckOut);

  // R5: acknowledge to the right is a single-cycle pulse
  assert_right_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rightAckOut |=> !rightAckOut);

  // R6: requests hold until acknowledged and fall right after
  assert_left_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txLeftReq && !leftAckIn) |=> txLeftReq);
  assert_left_req_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txLeftReq && leftAckIn) |=> !txLeftReq);
  assert_right_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txRightReq && !rightAckIn) |=> txRightReq);
  assert_right_req_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txRightReq && rightAckIn) |=> !txRightReq);

  // R7: a sensor pulse alone in idle is acknowledged next cycle
  assert_sensor_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && sensorHit && !emergLever && !rxLeftValid && !rxRightValid) |=> senseAckEn);

  // R9: stopped and idle with nothing pending releases the brakes
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && !anyEvent && speedLvl == '0 && forceLvl != '0) |=> (forceLvl == '0));

  // R10: one handshake activity at a time
  assert_single_activity_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txLeftReq, txRightReq, leftAckOut, rightAckOut, senseAckEn}));

endmodule

// File: rtl/brake_car_ctrl.sv
module brake_car_ctrl
  import brake_pkg::*;
#(
  parameter int FORCE_W     = 2,
  parameter int SPEED_W     = 2,
  parameter int NUM_SENSORS = 3,
  parameter int MAX_FORCE   = 2,
  parameter int HIGH_SPEED  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   emergLever,
  input  logic [NUM_SENSORS-1:0] distSense,
  input  logic [SPEED_W-1:0]     speedLvl,
  input  logic                   rxLeftValid,
  input  logic [FORCE_W-1:0]     rxLeftForce,
  input  logic                   rxRightValid,
  input  logic [FORCE_W-1:0]     rxRightForce,
  input  logic                   leftAckIn,
  input  logic                   rightAckIn,
  output logic [FORCE_W-1:0]     forceLvl,
  output logic                   txLeftReq,
  output logic                   txRightReq,
  output logic [FORCE_W-1:0]     txForce,
  output logic                   leftAckOut,
  output logic                   rightAckOut,
  output logic [NUM_SENSORS-1:0] sensAck
);

  dpStrobe_t              strobe;
  logic                   targetAbove;
  logic                   forceBelowMax;
  logic                   sensorHit;
  logic                   senseAckEn;
  logic [NUM_SENSORS-1:0] sensorSel;

  brake_control #(
    .FORCE_W(FORCE_W), .SPEED_W(SPEED_W), .HIGH_SPEED(HIGH_SPEED)
  ) u_control (
    .clk(clk), .rstN(rstN), .emergLever(emergLever),
    .rxLeftValid(rxLeftValid), .rxRightValid(rxRightValid),
    .leftAckIn(leftAckIn), .rightAckIn(rightAckIn),
    .sensorHit(sensorHit), .speedLvl(speedLvl), .forceLvl(forceLvl),
    .forceBelowMax(forceBelowMax), .targetAbove(targetAbove),
    .strobe(strobe), .txLeftReq(txLeftReq), .txRightReq(txRightReq),
    .leftAckOut(leftAckOut), .rightAckOut(rightAckOut), .senseAckEn(senseAckEn)
  );

  brake_datapath #(
    .FORCE_W(FORCE_W), .NUM_SENSORS(NUM_SENSORS), .MAX_FORCE(MAX_FORCE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rxLeftForce(rxLeftForce), .rxRightForce(rxRightForce), .distSense(distSense),
    .forceLvl(forceLvl), .targetLvl(txForce), .targetAbove(targetAbove),
    .forceBelowMax(forceBelowMax), .sensorHit(sensorHit), .sensorSel(sensorSel)
  );

  assign sensAck = senseAckEn ? sensorSel : '0;

endmodule

// File: tb/brake_car_ctrl_tb.sv
`timescale 1ns/1ps
module brake_car_ctrl_tb;

  localparam logic [3:0] K_FORCE = 4'd1, K_TXL = 4'd2, K_TXR = 4'd3,
                         K_ACKL = 4'd4, K_ACKR = 4'd5, K_SACK = 4'd6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       emergLever = 1'b0;
  logic [2:0] distSense = '0;
  logic [1:0] speedLvl = 2'd1;
  logic       rxLeftValid = 1'b0, rxRightValid = 1'b0;
  logic [1:0] rxLeftForce = '0, rxRightForce = '0;
  logic       leftAckIn = 1'b0, rightAckIn = 1'b0;
  logic [1:0] forceLvl, txForce;
  logic       txLeftReq, txRightReq, leftAckOut, rightAckOut;
  logic [2:0] sensAck;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  brake_car_ctrl u_dut (
    .clk(clk), .rstN(rstN), .emergLever(emergLever), .distSense(distSense),
    .speedLvl(speedLvl), .rxLeftValid(rxLeftValid), .rxLeftForce(rxLeftForce),
    .rxRightValid(rxRightValid), .rxRightForce(rxRightForce),
    .leftAckIn(leftAckIn), .rightAckIn(rightAckIn), .forceLvl(forceLvl),
    .txLeftReq(txLeftReq), .txRightReq(txRightReq), .txForce(txForce),
    .leftAckOut(leftAckOut), .rightAckOut(rightAckOut), .sensAck(sensAck)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_ev(input logic [3:0] kind, input int val, input string tag);
    expQ.push_back({kind, 4'(val)});
    tagQ.push_back(tag);
  endtask

  task automatic observe(input logic [3:0] kind, input int val);
    logic [7:0] got;
    logic [7:0] want;
    string      tag;
    got = {kind, 4'(val)};
    compared++;
    if (expQ.size() == 0) begin
      mismatched++;
      $display("FAIL R2 unexpected event actual=0x%02h expected=none at %0t", got, $time);
    end else begin
      want = expQ.pop_front();
      tag  = tagQ.pop_front();
      if (got != want) begin
        mismatched++;
        $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, got, want, $time);
      end
    end
  endtask

  // Monitor: turns port activity into events in a fixed in-cycle order
  initial begin
    logic [1:0] prevForce;
    logic       prevTxL, prevTxR;
    prevForce = '0; prevTxL = 1'b0; prevTxR = 1'b0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (sensAck != '0) observe(K_SACK, int'(sensAck));
      if (leftAckOut)    observe(K_ACKL, 0);
      if (rightAckOut)   observe(K_ACKR, 0);
      if (txLeftReq && !prevTxL)  observe(K_TXL, int'(txForce));
      if (txRightReq && !prevTxR) observe(K_TXR, int'(txForce));
      if (forceLvl != prevForce)  observe(K_FORCE, int'(forceLvl));
      prevForce = forceLvl; prevTxL = txLeftReq; prevTxR = txRightReq;
    end
  end

  // Neighbour responders: acknowledge after two cycles, check request drop (R6)
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (leftAckIn) begin
        leftAckIn = 1'b0;
        check("R6 left request drop", int'(txLeftReq), 0);
      end else if (txLeftReq) begin
        cnt++;
        if (cnt == 2) begin leftAckIn = 1'b1; cnt = 0; end
      end else cnt = 0;
    end
  end

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rightAckIn) begin
        rightAckIn = 1'b0;
        check("R6 right request drop", int'(txRightReq), 0);
      end else if (txRightReq) begin
        cnt++;
        if (cnt == 2) begin rightAckIn = 1'b1; cnt = 0; end
      end else cnt = 0;
    end
  end

  task automatic leftMsg(input logic [1:0] lvl);
    @(negedge clk);
    rxLeftValid = 1'b1; rxLeftForce = lvl;
    do @(negedge clk); while (!leftAckOut);
    rxLeftValid = 1'b0;
  endtask

  task automatic rightMsg(input logic [1:0] lvl);
    @(negedge clk);
    rxRightValid = 1'b1; rxRightForce = lvl;
    do @(negedge clk); while (!rightAckOut);
    rxRightValid = 1'b0;
  endtask

  task automatic pulseLever();
    @(negedge clk); emergLever = 1'b1;
    @(negedge clk); emergLever = 1'b0;
  endtask

  task automatic pulseSensor(input logic [2:0] mask);
    @(negedge clk); distSense = mask;
    @(negedge clk); distSense = '0;
  endtask

  task automatic setSpeed(input logic [1:0] v);
    @(negedge clk); speedLvl = v;
  endtask

  task automatic settle(input string tag);
    repeat (20) @(negedge clk);
    while (expQ.size() != 0) begin
      void'(expQ.pop_front());
      compared++; mismatched++;
      $display("FAIL %s actual=missing expected=%s at %0t", tag, tagQ.pop_front(), $time);
    end
  endtask

  task automatic release_to_zero();
    expect_ev(K_FORCE, 0, "R9 release");
    setSpeed(2'd0);
    settle("R9 release");
    setSpeed(2'd1);
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 force at reset", int'(forceLvl), 0);
    check("R1 outputs at reset",
          int'({txLeftReq, txRightReq, leftAckOut, rightAckOut, sensAck}), 0);
    rstN = 1'b1;
    settle("R2 idle hold");
    check("R2 force held idle", int'(forceLvl), 0);

    // R4: left message level 1 at force 0 is acknowledged, forwarded right, adopted
    expect_ev(K_ACKL, 0, "R4 ack left");
    expect_ev(K_TXR, 1, "R4 forward right");
    expect_ev(K_FORCE, 1, "R4 adopt");
    leftMsg(2'd1);
    settle("R4 left message");
    check("R4 force after left message", int'(forceLvl), 1);

    // R5: right message at same level is only acknowledged
    expect_ev(K_ACKR, 0, "R5 ack right, not higher");
    rightMsg(2'd1);
    settle("R5 not higher");
    check("R5 force unchanged", int'(forceLvl), 1);

    // R3: lever at medium force
    expect_ev(K_TXL, 2, "R3 left first");
    expect_ev(K_TXR, 2, "R3 then right");
    expect_ev(K_FORCE, 2, "R3 commit high");
    pulseLever();
    settle("R3 lever");
    check("R3 force after lever", int'(forceLvl), 2);

    // R3: lever at high force is ignored
    pulseLever();
    settle("R3 lever at max");
    check("R3 force stays high", int'(forceLvl), 2);

    // R7: sensor at high speed with force already high: ack only
    setSpeed(2'd2);
    expect_ev(K_SACK, 2, "R7 sensor 2 at max");
    pulseSensor(3'b010);
    settle("R7 sensor at max");
    setSpeed(2'd1);

    release_to_zero();
    check("R9 force zero", int'(forceLvl), 0);
    setSpeed(2'd0);
    settle("R9 already zero");
    setSpeed(2'd1);

    // R5: right message level 2 at force 0
    expect_ev(K_ACKR, 0, "R5 ack right");
    expect_ev(K_TXL, 2, "R5 forward left");
    expect_ev(K_FORCE, 2, "R5 adopt");
    rightMsg(2'd2);
    settle("R5 right message");
    check("R5 force after right message", int'(forceLvl), 2);
    release_to_zero();

    // R7: sensor at medium speed leaves force, sensor at high speed escalates
    expect_ev(K_SACK, 2, "R7 sensor 2 medium speed");
    pulseSensor(3'b010);
    settle("R7 medium speed");
    check("R7 force unchanged", int'(forceLvl), 0);
    setSpeed(2'd2);
    expect_ev(K_SACK, 4, "R7 sensor 3 ack");
    expect_ev(K_TXL, 2, "R7 escalate left");
    expect_ev(K_TXR, 2, "R7 escalate right");
    expect_ev(K_FORCE, 2, "R7 escalate commit");
    pulseSensor(3'b100);
    settle("R7 high speed");
    check("R7 force escalated", int'(forceLvl), 2);
    setSpeed(2'd1);

    // R8: two sensors together, lower number wins, other dropped
    expect_ev(K_SACK, 1, "R8 sensor 1 wins");
    pulseSensor(3'b101);
    settle("R8 sensors");
    release_to_zero();

    // R8: lever and left message in the same cycle
    expect_ev(K_TXL, 2, "R8 lever first left");
    expect_ev(K_TXR, 2, "R8 lever first right");
    expect_ev(K_FORCE, 2, "R8 lever commit");
    expect_ev(K_ACKL, 0, "R8 left served later");
    fork
      pulseLever();
      leftMsg(2'd2);
    join
    settle("R8 lever vs left");
    check("R8 force after collision", int'(forceLvl), 2);
    release_to_zero();

    // R8: left and right messages in the same cycle
    expect_ev(K_ACKL, 0, "R8 left before right");
    expect_ev(K_TXR, 2, "R8 left forwarded");
    expect_ev(K_FORCE, 2, "R8 left adopted");
    expect_ev(K_ACKR, 0, "R8 right served later");
    fork
      leftMsg(2'd2);
      rightMsg(2'd2);
    join
    settle("R8 left vs right");
    check("R8 force after messages", int'(forceLvl), 2);
    check("R10 outputs quiet at end",
          int'({txLeftReq, txRightReq, leftAckOut, rightAckOut, sensAck}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule